// File: doc/BRIEF.md
# Core Clock-State Power Controller

This block is a synchronous controller that chooses the clock state of a mobile processor core. There are five states. In Normal the core runs and executes instructions. Auto Halt is entered after a halt instruction. Quick Start is a hardware idle state driven by a stop-clock request. Snoop Grant is a short state in which the clock runs again to service a bus snoop. Deep Sleep is the lowest-power state and is controlled by an active-low pin.

The controller produces three outputs: a core clock enable, a one-hot state word and a ready flag. The ready flag is low for the whole time the controller is in Deep Sleep, including the long wake-up latency after the pin is released. That latency is nominally 30 ms. It is set by the parameters `CLK_MHZ` (clock frequency in MHz) and `EXIT_US` (latency in microseconds), and the counted length is `CLK_MHZ*EXIT_US` cycles.

The controller follows only a fixed set of transitions. It silently ignores any request that does not belong to the current state. A core reset request overrides everything and returns the controller to Normal.

Top module: `core_clk_state_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the state word is `5'b00001` (Normal), `core_clk_en` is 1 and `core_ready` is 1.
- R2: In Normal, with `stopclk_req` low, a one-cycle `halt_strobe` moves the controller to Auto Halt (`5'b00010`) after the next clock edge.
- R3: In Auto Halt, any single high bit of `wake_evt` returns the controller to Normal after one edge. The bits are: 0 non-maskable interrupt, 1 maskable interrupt, 2 bus init, 3 processor init, 4 cache flush, 5 system-management interrupt.
- R4: A high `stopclk_req` in Normal or Auto Halt enters Quick Start (`5'b00100`). When the request drops, the controller returns to the state it left.
- R5: In Quick Start, with `stopclk_req` still high, a low `deep_sleep_n` enters Deep Sleep (`5'b10000`). `core_ready` is 0 throughout Deep Sleep.
- R6: The first clock edge that samples `deep_sleep_n` high in Deep Sleep starts the exit count. The controller stays in Deep Sleep for exactly `CLK_MHZ*EXIT_US` edges counted from that edge. It then enters Quick Start, and `core_ready` returns to 1.
- R7: A high `snoop_req` in Auto Halt or Quick Start enters Snoop Grant (`5'b01000`). When `snoop_req` drops, the controller returns to the state it left.
- R8: `core_clk_en` is 1 only in Normal and in Snoop Grant.
- R9: A high `core_rst_req` forces Normal after one edge from any state. It cancels an exit count in progress, so a later Deep Sleep exit again takes the full count.
- R10: The following requests cause no change of state: `halt_strobe` outside Normal, `wake_evt` outside Auto Halt, a low `deep_sleep_n` outside Quick Start, and `snoop_req` in Normal.
- R11: `state_oh` always has exactly one bit set. The bit positions are: 0 Normal, 1 Auto Halt, 2 Quick Start, 3 Snoop Grant, 4 Deep Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_strobe | input | 1 | One-cycle pulse when a halt instruction retires |
| wake_evt | input | 6 | Active-high halt break events (see R3) |
| core_rst_req | input | 1 | Active-high core reset request, overrides all states |
| stopclk_req | input | 1 | Stop-clock request level |
| deep_sleep_n | input | 1 | Active-low deep-sleep request level |
| snoop_req | input | 1 | Snoop request, held until the snoop completes |
| core_clk_en | output | 1 | Core clock enable |
| state_oh | output | 5 | One-hot current state |
| core_ready | output | 1 | Low during Deep Sleep and its exit latency |

## Verification
The assertions assume that the inputs are synchronous to `clk` and only change between edges. They also assume that `snoop_req` stays high until the snoop is finished and that `stopclk_req` stays high throughout a Deep Sleep episode. The stimulus drives every input on the falling edge and raises one request at a time. It holds `stopclk_req` high from Quick Start entry until the controller is back in Quick Start, and it releases `snoop_req` only after it has seen the Snoop Grant state.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

    localparam int NUM_STATES = 5;
    localparam int NUM_WAKE   = 6;

    // wake event bit positions
    localparam int WK_NMI   = 0;
    localparam int WK_INTR  = 1;
    localparam int WK_BUSI  = 2;
    localparam int WK_INIT  = 3;
    localparam int WK_FLUSH = 4;
    localparam int WK_SMI   = 5;

    typedef enum logic [2:0] {
        CS_NORMAL = 3'd0,
        CS_HALT   = 3'd1,
        CS_QSTART = 3'd2,
        CS_SNOOP  = 3'd3,
        CS_DSLEEP = 3'd4
    } cstate_e;

    typedef struct packed {
        logic halt;
        logic wake;
        logic rst_req;
        logic stop;
        logic ds_n;
        logic snoop;
    } cstate_req_t;

    function automatic logic [NUM_STATES-1:0] state_onehot(input cstate_e s);
        logic [NUM_STATES-1:0] oh;
        oh = '0;
        oh[s] = 1'b1;
        return oh;
    endfunction

    function automatic logic state_clk_runs(input cstate_e s);
        return (s == CS_NORMAL) || (s == CS_SNOOP);
    endfunction

endpackage

// File: rtl/cstate_wake_detect.sv
module cstate_wake_detect
    import cstate_pkg::*;
#(
    parameter logic [NUM_WAKE-1:0] WAKE_EN = '1
) (
    input  logic [NUM_WAKE-1:0] evt,
    output logic                any_evt
);
    logic [NUM_WAKE-1:0] masked;

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_mask
        if (WAKE_EN[i]) begin : g_on
            assign masked[i] = evt[i];
        end else begin : g_off
            assign masked[i] = 1'b0;
        end
    end

    assign any_evt = |masked;

endmodule

// File: rtl/cstate_exit_timer.sv
module cstate_exit_timer #(
    parameter int CYCLES = 3000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // the count never runs past its final value (R6)
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST));

    // a clear always leaves the timer idle (R9)
    assert_clear_idle_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !busy);

endmodule

// File: rtl/cstate_next.sv
module cstate_next
    import cstate_pkg::*;
(
    input  cstate_e     cur,
    input  cstate_e     qs_ret,
    input  cstate_e     snp_ret,
    input  cstate_req_t req,
    input  logic        exit_busy,
    input  logic        exit_done,
    output cstate_e     nxt,
    output cstate_e     nxt_qs_ret,
    output cstate_e     nxt_snp_ret,
    output logic        exit_start,
    output logic        exit_clear
);
    always_comb begin
        nxt         = cur;
        nxt_qs_ret  = qs_ret;
        nxt_snp_ret = snp_ret;
        exit_start  = 1'b0;
        exit_clear  = 1'b0;
        if (req.rst_req) begin
            nxt         = CS_NORMAL;
            nxt_qs_ret  = CS_NORMAL;
            nxt_snp_ret = CS_HALT;
            exit_clear  = 1'b1;
        end else begin
            case (cur)
                CS_NORMAL: begin
                    if (req.stop) begin
                        nxt        = CS_QSTART;
                        nxt_qs_ret = CS_NORMAL;
                    end else if (req.halt) begin
                        nxt = CS_HALT;
                    end
                end
                CS_HALT: begin
                    if (req.wake) begin
                        nxt = CS_NORMAL;
                    end else if (req.stop) begin
                        nxt        = CS_QSTART;
                        nxt_qs_ret = CS_HALT;
                    end else if (req.snoop) begin
                        nxt         = CS_SNOOP;
                        nxt_snp_ret = CS_HALT;
                    end
                end
                CS_QSTART: begin
                    if (!req.stop) begin
                        nxt = qs_ret;
                    end else if (!req.ds_n) begin
                        nxt = CS_DSLEEP;
                    end else if (req.snoop) begin
                        nxt         = CS_SNOOP;
                        nxt_snp_ret = CS_QSTART;
                    end
                end
                CS_SNOOP: begin
                    if (!req.snoop) begin
                        nxt = snp_ret;
                    end
                end
                CS_DSLEEP: begin
                    if (exit_done) begin
                        nxt = CS_QSTART;
                    end else if (req.ds_n && !exit_busy) begin
                        exit_start = 1'b1;
                    end
                end
                default: nxt = CS_NORMAL;
            endcase
        end
    end
endmodule

// File: rtl/core_clk_state_ctrl.sv
module core_clk_state_ctrl
    import cstate_pkg::*;
#(
    parameter int                   CLK_MHZ = 100,
    parameter int                   EXIT_US = 30000,
    parameter logic [NUM_WAKE-1:0]  WAKE_EN = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    halt_strobe,
    input  logic [NUM_WAKE-1:0]     wake_evt,
    input  logic                    core_rst_req,
    input  logic                    stopclk_req,
    input  logic                    deep_sleep_n,
    input  logic                    snoop_req,
    output logic                    core_clk_en,
    output logic [NUM_STATES-1:0]   state_oh,
    output logic                    core_ready
);
    localparam int EXIT_CYCLES = (CLK_MHZ * EXIT_US < 1) ? 1 : CLK_MHZ * EXIT_US;

    cstate_e     state, state_nxt;
    cstate_e     qs_ret, qs_ret_nxt;
    cstate_e     snp_ret, snp_ret_nxt;
    cstate_req_t req;
    logic        wake_any;
    logic        exit_busy, exit_done, exit_start, exit_clear;

    cstate_wake_detect #(.WAKE_EN(WAKE_EN)) u_wake (
        .evt     (wake_evt),
        .any_evt (wake_any)
    );

    always_comb begin
        req.halt    = halt_strobe;
        req.wake    = wake_any;
        req.rst_req = core_rst_req;
        req.stop    = stopclk_req;
        req.ds_n    = deep_sleep_n;
        req.snoop   = snoop_req;
    end

    cstate_exit_timer #(.CYCLES(EXIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (exit_clear),
        .start (exit_start),
        .busy  (exit_busy),
        .done  (exit_done)
    );

    cstate_next u_next (
        .cur         (state),
        .qs_ret      (qs_ret),
        .snp_ret     (snp_ret),
        .req         (req),
        .exit_busy   (exit_busy),
        .exit_done   (exit_done),
        .nxt         (state_nxt),
        .nxt_qs_ret  (qs_ret_nxt),
        .nxt_snp_ret (snp_ret_nxt),
        .exit_start  (exit_start),
        .exit_clear  (exit_clear)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CS_NORMAL;
            qs_ret  <= CS_NORMAL;
            snp_ret <= CS_HALT;
        end else begin
            state   <= state_nxt;
            qs_ret  <= qs_ret_nxt;
            snp_ret <= snp_ret_nxt;
        end
    end

    assign state_oh    = state_onehot(state);
    assign core_clk_en = state_clk_runs(state);
    assign core_ready  = (state != CS_DSLEEP);

    assert_state_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

    assert_clk_en_states_R8: assert property (@(posedge clk) disable iff (rst)
        core_clk_en |-> (state_oh[0] || state_oh[3]));

    assert_not_ready_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        state_oh[4] |-> !core_ready);

    assert_rst_req_normal_R9: assert property (@(posedge clk) disable iff (rst)
        core_rst_req |=> state_oh[0]);

    assert_wake_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (state_oh[1] && wake_any && !core_rst_req) |=> state_oh[0]);

    assert_sleep_from_qs_R5: assert property (@(posedge clk) disable iff (rst)
        (state_oh[4] && !$past(state_oh[4])) |-> $past(state_oh[2]));

    assert_snoop_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (state_oh[0] && snoop_req && !halt_strobe && !stopclk_req && !core_rst_req)
        |=> state_oh[0]);

    assert_exit_counting_R6: assert property (@(posedge clk) disable iff (rst)
        (exit_busy && !exit_done && !core_rst_req) |=> state_oh[4]);

endmodule

// File: tb/test_core_clk_state_ctrl.sv
module test_core_clk_state_ctrl;
    localparam int CLK_MHZ = 1;
    localparam int EXIT_US = 20;
    localparam int EXIT_N  = CLK_MHZ * EXIT_US;

    localparam logic [4:0] S_NORM = 5'b00001;
    localparam logic [4:0] S_HALT = 5'b00010;
    localparam logic [4:0] S_QS   = 5'b00100;
    localparam logic [4:0] S_SNP  = 5'b01000;
    localparam logic [4:0] S_DS   = 5'b10000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_strobe = 1'b0;
    logic [5:0] wake_evt = '0;
    logic       core_rst_req = 1'b0;
    logic       stopclk_req = 1'b0;
    logic       deep_sleep_n = 1'b1;
    logic       snoop_req = 1'b0;
    logic       core_clk_en;
    logic [4:0] state_oh;
    logic       core_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    core_clk_state_ctrl #(.CLK_MHZ(CLK_MHZ), .EXIT_US(EXIT_US)) i_core_clk_state_ctrl (
        .clk          (clk),
        .rst          (rst),
        .halt_strobe  (halt_strobe),
        .wake_evt     (wake_evt),
        .core_rst_req (core_rst_req),
        .stopclk_req  (stopclk_req),
        .deep_sleep_n (deep_sleep_n),
        .snoop_req    (snoop_req),
        .core_clk_en  (core_clk_en),
        .state_oh     (state_oh),
        .core_ready   (core_ready)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [4:0] st, input logic en, input logic rdy);
        n_checks++;
        if (state_oh !== st || core_clk_en !== en || core_ready !== rdy) begin
            n_fail++;
            $display("FAIL %s: state=%b en=%b rdy=%b expected state=%b en=%b rdy=%b",
                     tag, state_oh, core_clk_en, core_ready, st, en, rdy);
        end
    endtask

    task automatic go_normal();
        core_rst_req = 1'b1;
        step();
        core_rst_req = 1'b0;
    endtask

    task automatic go_halt();
        halt_strobe = 1'b1;
        step();
        halt_strobe = 1'b0;
    endtask

    task automatic t_reset();
        step();
        expect_out("R1 in reset", S_NORM, 1'b1, 1'b1);
        rst = 1'b0;
        step();
        expect_out("R1 after reset", S_NORM, 1'b1, 1'b1);
    endtask

    task automatic t_halt_wake();
        for (int i = 0; i < 6; i++) begin
            go_halt();
            expect_out("R2 halt entry", S_HALT, 1'b0, 1'b1);
            wake_evt = 6'(1 << i);
            step();
            wake_evt = '0;
            expect_out($sformatf("R3 wake bit %0d", i), S_NORM, 1'b1, 1'b1);
        end
    endtask

    task automatic t_stopclk();
        stopclk_req = 1'b1;
        step();
        expect_out("R4 qs from normal", S_QS, 1'b0, 1'b1);
        stopclk_req = 1'b0;
        step();
        expect_out("R4 back to normal", S_NORM, 1'b1, 1'b1);
        go_halt();
        stopclk_req = 1'b1;
        step();
        expect_out("R4 qs from halt", S_QS, 1'b0, 1'b1);
        stopclk_req = 1'b0;
        step();
        expect_out("R4 back to halt", S_HALT, 1'b0, 1'b1);
        go_normal();
    endtask

    task automatic t_snoop();
        go_halt();
        snoop_req = 1'b1;
        step();
        expect_out("R7 snoop from halt R8", S_SNP, 1'b1, 1'b1);
        snoop_req = 1'b0;
        step();
        expect_out("R7 back to halt", S_HALT, 1'b0, 1'b1);
        stopclk_req = 1'b1;
        step();
        snoop_req = 1'b1;
        step();
        expect_out("R7 snoop from qs", S_SNP, 1'b1, 1'b1);
        snoop_req = 1'b0;
        step();
        expect_out("R7 back to qs", S_QS, 1'b0, 1'b1);
        stopclk_req = 1'b0;
        step();
        expect_out("R4 qs returns halt after snoop", S_HALT, 1'b0, 1'b1);
        go_normal();
    endtask

    task automatic t_deep_sleep();
        stopclk_req = 1'b1;
        step();
        deep_sleep_n = 1'b0;
        step();
        expect_out("R5 deep sleep entry", S_DS, 1'b0, 1'b0);
        step();
        expect_out("R5 stays asleep", S_DS, 1'b0, 1'b0);
        deep_sleep_n = 1'b1;
        repeat (EXIT_N) @(posedge clk);
        @(negedge clk);
        expect_out("R6 still exiting at N-1", S_DS, 1'b0, 1'b0);
        step();
        expect_out("R6 exit to qs", S_QS, 1'b0, 1'b1);
        stopclk_req = 1'b0;
        step();
        expect_out("R4 qs back to normal", S_NORM, 1'b1, 1'b1);
    endtask

    task automatic t_rst_req();
        go_halt();
        go_normal();
        expect_out("R9 halt to normal", S_NORM, 1'b1, 1'b1);
        stopclk_req = 1'b1;
        step();
        deep_sleep_n = 1'b0;
        step();
        deep_sleep_n = 1'b1;
        repeat (5) step();
        expect_out("R9 mid exit", S_DS, 1'b0, 1'b0);
        core_rst_req = 1'b1;
        step();
        core_rst_req = 1'b0;
        expect_out("R9 rst aborts exit", S_NORM, 1'b1, 1'b1);
        step();
        expect_out("R4 stopclk after rst", S_QS, 1'b0, 1'b1);
        deep_sleep_n = 1'b0;
        step();
        deep_sleep_n = 1'b1;
        repeat (EXIT_N) @(posedge clk);
        @(negedge clk);
        expect_out("R9 full count again", S_DS, 1'b0, 1'b0);
        step();
        expect_out("R9 exit after full count", S_QS, 1'b0, 1'b1);
        stopclk_req = 1'b0;
        step();
    endtask

    task automatic t_ignored();
        deep_sleep_n = 1'b0;
        snoop_req = 1'b1;
        wake_evt = 6'h3F;
        step();
        expect_out("R10 ignored in normal", S_NORM, 1'b1, 1'b1);
        snoop_req = 1'b0;
        wake_evt = '0;
        go_halt();
        expect_out("R10 sleep pin ignored in halt", S_HALT, 1'b0, 1'b1);
        deep_sleep_n = 1'b1;
        halt_strobe = 1'b1;
        step();
        halt_strobe = 1'b0;
        expect_out("R10 halt in halt", S_HALT, 1'b0, 1'b1);
        stopclk_req = 1'b1;
        step();
        halt_strobe = 1'b1;
        wake_evt = 6'h3F;
        step();
        halt_strobe = 1'b0;
        wake_evt = '0;
        expect_out("R10 halt and wake in qs", S_QS, 1'b0, 1'b1);
        stopclk_req = 1'b0;
        step();
        go_normal();
        expect_out("R11 final normal", S_NORM, 1'b1, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_halt_wake();
        t_stopclk();
        t_snoop();
        t_deep_sleep();
        t_rst_req();
        t_ignored();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule